// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches every cycle on a CPU bus and raises a break request when a cycle meets the conditions programmed into one of its two channels, A and B. Each channel compares the cycle's address against a programmed address and ignores the bits set in an address mask. For data accesses it also compares the data against a programmed value, with its own mask. A cycle qualifier restricts the match by bus, by fetch versus data access, by direction and, if wanted, by access size. Instruction-fetch matches are meant to stop the CPU before the fetched instruction runs. The CPU side uses the request for that and is outside this block.

The two channels can fire on their own (independent mode). They can also be chained (sequential mode): a channel A match arms the unit, and only a later channel B match produces the break. Software programs the channels through a simple indexed write port. It sees which channel caused a break through sticky per-channel match flags, which it clears with write-one-to-clear.

Top module: `bus_brk_unit`

## Requirements
- R1: After reset every register is zero, `brk_req` is 0 and `match_flag` is 2'b00. A zero qualifier never matches.
- R2: Register map on `reg_idx`: channel A uses 0..4 and channel B uses 5..9, in the order address, address mask, data, data mask, qualifier. Index 10 is control and index 11 is flag clear. In independent mode, a bus cycle that matches a channel drives `brk_req` high in the next cycle for one cycle and sets that channel's bit in `match_flag` (bit 0 = A, bit 1 = B). Both channels may match in the same cycle.
- R3: A set address mask bit removes that address bit from the comparison. An all-zero mask requires an exact address match.
- R4: Qualifier bits: [1:0] cycle kind (01 fetch, 10 data, 11 either, 00 none); [3:2] direction (01 read, 10 write, 11 either, 00 none); [5:4] size (00 any, 01 byte, 10 word, 11 long); [6] only cycles with `bus_local`=1. `bus_size` is 0 for byte, 1 for word and 2 for long. A size field of 00 accepts every size.
- R5: Fetch cycles count as reads, so a channel qualified for fetch with write direction only never matches.
- R6: A fetch cycle at an odd address never matches.
- R7: Fetch cycles skip the data comparison. Data cycles compare only the byte lanes the access covers, selected by `bus_size` and the low address bits (byte lane = addr[1:0], word half = addr[1]). Data mask bits set to 1 are excluded.
- R8: Match flags stay set until written with a 1 at index 11 (bit 0 clears A, bit 1 clears B). A match in the same cycle wins over the clear.
- R9: Control bit 3 selects sequential mode. In this mode a channel B match before the unit is armed gives no break. Once a channel A match has armed the unit, the next channel B match gives the break, sets flag B and disarms. Arming sets flag A. The armed state persists across non-matching cycles.
- R10: In sequential mode, a cycle that matches both channels while not armed only arms the unit and gives no break.
- R11: Any write to the control register clears the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_local | input | 1 | Cycle is on the CPU-local bus |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 long |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| brk_req | output | 1 | Break request, one cycle per break |
| match_flag | output | 2 | Sticky match flags, bit 0 channel A, bit 1 channel B |

## Verification
Exact-address fetches are tried next to a neighbouring address, which shows whether every unmasked bit is compared. A masked data window is tried with an address inside it and one just outside. Sized and size-agnostic qualifiers get cycles of every size, and direction-restricted qualifiers get both directions. These separate the size, kind and direction decoding, including the fetch-with-write and odd-fetch cases. Byte-lane data patterns change only the covered lane or only the uncovered lanes. Chained runs present B before A, A and B together, A then idle then B, and a control rewrite between A and B, which tells arming apart from firing and from disarming.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int BRK_AW = 32;
  localparam int BRK_DW = 32;

  typedef struct packed {
    logic       local_only;
    logic [1:0] size;
    logic [1:0] dir;
    logic [1:0] kind;
  } cond_t;

  localparam int COND_W = $bits(cond_t);

  function automatic logic kind_ok(input logic [1:0] kind, input logic fetch);
    return fetch ? kind[0] : kind[1];
  endfunction

  function automatic logic dir_ok(input logic [1:0] dir, input logic fetch, input logic wr);
    logic wr_eff;
    wr_eff = wr & ~fetch;
    return wr_eff ? dir[1] : dir[0];
  endfunction

  function automatic logic size_ok(input logic [1:0] want, input logic [1:0] bsz);
    return (want == 2'd0) || (want == bsz + 2'd1);
  endfunction

  function automatic logic [BRK_DW-1:0] lane_mask(input logic [1:0] bsz, input logic [1:0] lo);
    logic [BRK_DW-1:0] m;
    case (bsz)
      2'd0:    m = {{(BRK_DW-8){1'b0}}, 8'hFF} << {lo, 3'b000};
      2'd1:    m = {{(BRK_DW-16){1'b0}}, 16'hFFFF} << {lo[1], 4'b0000};
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int AW   = BRK_AW,
  parameter int DW   = BRK_DW,
  parameter int RIDX = 4,
  parameter int SEQ_BIT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [RIDX-1:0]           reg_idx,
  input  logic [AW-1:0]             reg_wdata,
  output logic [NCH-1:0][AW-1:0]    c_addr,
  output logic [NCH-1:0][AW-1:0]    c_amask,
  output logic [NCH-1:0][DW-1:0]    c_data,
  output logic [NCH-1:0][DW-1:0]    c_dmask,
  output cond_t [NCH-1:0]           c_cond,
  output logic                      seq_mode,
  output logic                      ctrl_wr,
  output logic [NCH-1:0]            clr
);
  localparam int REGS_PER_CH = 5;
  localparam logic [RIDX-1:0] CTRL_IDX = RIDX'(NCH * REGS_PER_CH);
  localparam logic [RIDX-1:0] CLR_IDX  = RIDX'(NCH * REGS_PER_CH + 1);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [RIDX-1:0] I_ADDR  = RIDX'(ch * REGS_PER_CH + 0);
    localparam logic [RIDX-1:0] I_AMASK = RIDX'(ch * REGS_PER_CH + 1);
    localparam logic [RIDX-1:0] I_DATA  = RIDX'(ch * REGS_PER_CH + 2);
    localparam logic [RIDX-1:0] I_DMASK = RIDX'(ch * REGS_PER_CH + 3);
    localparam logic [RIDX-1:0] I_COND  = RIDX'(ch * REGS_PER_CH + 4);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c_addr[ch]  <= '0;
        c_amask[ch] <= '0;
        c_data[ch]  <= '0;
        c_dmask[ch] <= '0;
        c_cond[ch]  <= '0;
      end else if (reg_we) begin
        if (reg_idx == I_ADDR)  c_addr[ch]  <= reg_wdata;
        if (reg_idx == I_AMASK) c_amask[ch] <= reg_wdata;
        if (reg_idx == I_DATA)  c_data[ch]  <= reg_wdata[DW-1:0];
        if (reg_idx == I_DMASK) c_dmask[ch] <= reg_wdata[DW-1:0];
        if (reg_idx == I_COND)  c_cond[ch]  <= cond_t'(reg_wdata[COND_W-1:0]);
      end
    end
  end

  assign ctrl_wr = reg_we && (reg_idx == CTRL_IDX);
  assign clr     = (reg_we && (reg_idx == CLR_IDX)) ? reg_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       seq_mode <= 1'b0;
    else if (ctrl_wr) seq_mode <= reg_wdata[SEQ_BIT];
  end
endmodule

// File: rtl/brk_chan_match.sv
module brk_chan_match
  import brk_pkg::*;
#(
  parameter int AW = BRK_AW,
  parameter int DW = BRK_DW
) (
  input  logic          bus_valid,
  input  logic          bus_local,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [AW-1:0] c_addr,
  input  logic [AW-1:0] c_amask,
  input  logic [DW-1:0] c_data,
  input  logic [DW-1:0] c_dmask,
  input  cond_t         c_cond,
  output logic          hit
);
  logic cyc_ok, addr_ok, align_ok, data_ok;

  assign cyc_ok   = kind_ok(c_cond.kind, bus_fetch)
                 && dir_ok(c_cond.dir, bus_fetch, bus_write)
                 && size_ok(c_cond.size, bus_size)
                 && (!c_cond.local_only || bus_local);
  assign addr_ok  = ((bus_addr ^ c_addr) & ~c_amask) == '0;
  assign align_ok = !bus_fetch || !bus_addr[0];
  assign data_ok  = bus_fetch
                 || (((bus_data ^ c_data) & ~c_dmask & lane_mask(bus_size, bus_addr[1:0])) == '0);
  assign hit      = bus_valid && cyc_ok && addr_ok && align_ok && data_ok;
endmodule

// File: rtl/brk_seq.sv
module brk_seq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           seq_mode,
  input  logic           ctrl_wr,
  input  logic [NCH-1:0] clr,
  output logic           brk_req,
  output logic [NCH-1:0] flag,
  output logic           armed
);
  logic           req_n, arm_n;
  logic [NCH-1:0] set_n;

  always_comb begin
    req_n = 1'b0;
    set_n = '0;
    arm_n = armed;
    if (!seq_mode) begin
      req_n = |hit;
      set_n = hit;
      arm_n = 1'b0;
    end else if (armed) begin
      req_n    = hit[1];
      set_n[1] = hit[1];
      if (hit[1]) arm_n = 1'b0;
    end else begin
      set_n[0] = hit[0];
      arm_n    = hit[0];
    end
    if (ctrl_wr) arm_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_req <= 1'b0;
      flag    <= '0;
      armed   <= 1'b0;
    end else begin
      brk_req <= req_n;
      flag    <= (flag & ~clr) | set_n;
      armed   <= arm_n;
    end
  end
endmodule

// File: rtl/bus_brk_unit.sv
module bus_brk_unit
  import brk_pkg::*;
#(
  parameter int AW   = BRK_AW,
  parameter int DW   = BRK_DW,
  parameter int RIDX = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_local,
  input  logic            bus_fetch,
  input  logic            bus_write,
  input  logic [1:0]      bus_size,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_data,
  input  logic            reg_we,
  input  logic [RIDX-1:0] reg_idx,
  input  logic [AW-1:0]   reg_wdata,
  output logic            brk_req,
  output logic [1:0]      match_flag
);
  localparam int NCH = 2;

  logic [NCH-1:0][AW-1:0] c_addr, c_amask;
  logic [NCH-1:0][DW-1:0] c_data, c_dmask;
  cond_t [NCH-1:0]        c_cond;
  logic                   seq_mode, ctrl_wr, armed;
  logic [NCH-1:0]         clr, hit;
  logic                   hit_a, hit_b;

  brk_regs #(.NCH(NCH), .AW(AW), .DW(DW), .RIDX(RIDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .c_addr(c_addr), .c_amask(c_amask), .c_data(c_data), .c_dmask(c_dmask), .c_cond(c_cond),
    .seq_mode(seq_mode), .ctrl_wr(ctrl_wr), .clr(clr)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_match
    brk_chan_match #(.AW(AW), .DW(DW)) u_match (
      .bus_valid(bus_valid), .bus_local(bus_local), .bus_fetch(bus_fetch),
      .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr), .bus_data(bus_data),
      .c_addr(c_addr[ch]), .c_amask(c_amask[ch]), .c_data(c_data[ch]),
      .c_dmask(c_dmask[ch]), .c_cond(c_cond[ch]), .hit(hit[ch])
    );
  end

  assign hit_a = hit[0];
  assign hit_b = hit[1];

  brk_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .hit(hit), .seq_mode(seq_mode), .ctrl_wr(ctrl_wr),
    .clr(clr), .brk_req(brk_req), .flag(match_flag), .armed(armed)
  );
endmodule

// File: rtl/bus_brk_chk.sv
module bus_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brk_req,
  input logic [1:0] flag,
  input logic       hit_a,
  input logic       hit_b,
  input logic       armed,
  input logic       seq_mode,
  input logic [1:0] clr,
  input logic       bus_fetch,
  input logic       bus_addr_lsb
);
  assert_req_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(hit_a || hit_b));

  assert_indep_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode && (hit_a || hit_b)) |=> brk_req);

  assert_fetch_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_a || hit_b) && bus_fetch) |-> !bus_addr_lsb);

  assert_flag_a_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !clr[0]) |=> flag[0]);

  assert_flag_b_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[1] && !clr[1]) |=> flag[1]);

  assert_seq_needs_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_mode) && brk_req) |-> $past(armed && hit_b));

  assert_unarmed_no_break_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && !armed) |=> !brk_req);
endmodule

bind bus_brk_unit bus_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .flag(match_flag),
  .hit_a(hit_a), .hit_b(hit_b), .armed(armed), .seq_mode(seq_mode),
  .clr(clr), .bus_fetch(bus_fetch), .bus_addr_lsb(bus_addr[0])
);

// File: tb/bus_brk_unit_bench.sv
module bus_brk_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_local = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic        brk_req;
  logic [1:0]  match_flag;

  int n_chk = 0, n_fail = 0;

  logic       q_req[$];
  logic [1:0] q_flg[$];
  string      q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_brk_unit u_bus_brk_unit (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_local(bus_local),
    .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_data(bus_data), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .brk_req(brk_req), .match_flag(match_flag)
  );

  task automatic check(input logic req, input logic [1:0] flg, input string tag);
    n_chk++;
    if (brk_req !== req || match_flag !== flg) begin
      n_fail++;
      $display("FAIL %s: req=%b flags=%b expected req=%b flags=%b", tag, brk_req, match_flag, req, flg);
    end
  endtask

  // monitor: compares the scoreboard entry after the edge that registers it
  always @(posedge clk) begin
    #1;
    if (q_req.size() > 0) check(q_req.pop_front(), q_flg.pop_front(), q_tag.pop_front());
  end

  task automatic wr(input logic [3:0] idx, input logic [31:0] val);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cyc(input logic fetch, input logic wr_dir, input logic [1:0] sz,
                     input logic [31:0] addr, input logic [31:0] data, input logic loc,
                     input logic exp_req, input logic [1:0] exp_flg, input string tag);
    bus_valid = 1'b1; bus_fetch = fetch; bus_write = wr_dir; bus_size = sz;
    bus_addr = addr; bus_data = data; bus_local = loc;
    q_req.push_back(exp_req); q_flg.push_back(exp_flg); q_tag.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] addr, input logic exp_req, input logic [1:0] exp_flg,
                       input string tag);
    cyc(1'b1, 1'b0, 2'd1, addr, 32'h0, 1'b1, exp_req, exp_flg, tag);
  endtask

  task automatic idle(input logic [1:0] exp_flg, input string tag);
    q_req.push_back(1'b0); q_flg.push_back(exp_flg); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(1'b0, 2'b00, "R1 reset state");
    idle(2'b00, "R1 zero qualifiers never match");

    // channel A: exact fetch at 0x37226, word, local bus (qual 0x65)
    wr(4'd0, 32'h0003_7226); wr(4'd4, 32'h65);
    fetch(32'h0003_7224, 1'b0, 2'b00, "R3 exact mask rejects neighbour");
    fetch(32'h0003_7226, 1'b1, 2'b01, "R2 exact fetch match");
    idle(2'b01, "R2 single pulse / R8 flag held");
    wr(4'd11, 32'h1);
    idle(2'b00, "R8 flag A cleared");
    cyc(1'b1, 1'b0, 2'd1, 32'h0003_7226, 32'h0, 1'b0, 1'b0, 2'b00, "R4 other bus rejected");
    cyc(1'b1, 1'b0, 2'd2, 32'h0003_7226, 32'h0, 1'b1, 1'b0, 2'b00, "R4 wrong size rejected");

    // fetch + write qualifier (0x69)
    wr(4'd4, 32'h69);
    fetch(32'h0003_7226, 1'b0, 2'b00, "R5 fetch with write qualifier");

    // channel B: masked data read window, any size, data ignored (qual 0x46)
    wr(4'd5, 32'h0003_1400); wr(4'd6, 32'hFF); wr(4'd8, 32'hFFFF_FFFF); wr(4'd9, 32'h46);
    cyc(1'b0, 1'b0, 2'd2, 32'h0003_14AC, 32'h1234, 1'b1, 1'b1, 2'b10, "R3 masked match");
    cyc(1'b0, 1'b0, 2'd2, 32'h0003_15AC, 32'h1234, 1'b1, 1'b0, 2'b10, "R3 outside mask");
    wr(4'd11, 32'h2);

    // odd fetch address (qual 0x45 fetch/read/any size)
    wr(4'd5, 32'h0003_1415); wr(4'd6, 32'h0); wr(4'd9, 32'h45);
    cyc(1'b1, 1'b0, 2'd1, 32'h0003_1415, 32'h0, 1'b1, 1'b0, 2'b00, "R6 odd fetch");
    wr(4'd5, 32'h0003_1414);
    cyc(1'b1, 1'b0, 2'd2, 32'h0003_1414, 32'h0, 1'b1, 1'b1, 2'b10, "R4 any size long");
    cyc(1'b1, 1'b0, 2'd0, 32'h0003_1414, 32'h0, 1'b1, 1'b1, 2'b10, "R4 any size byte");
    wr(4'd11, 32'h2);

    // channel A: data write byte at 0x1000 (qual 0x5A)
    wr(4'd0, 32'h0000_1000); wr(4'd4, 32'h5A);
    cyc(1'b0, 1'b1, 2'd1, 32'h0000_1000, 32'h0, 1'b1, 1'b0, 2'b00, "R4 word vs byte qualifier");
    cyc(1'b0, 1'b0, 2'd0, 32'h0000_1000, 32'h0, 1'b1, 1'b0, 2'b00, "R4 read vs write qualifier");
    cyc(1'b0, 1'b1, 2'd0, 32'h0000_1000, 32'h0, 1'b1, 1'b1, 2'b01, "R4 byte write match");
    wr(4'd11, 32'h1);

    // byte lanes: byte read at 0x2002, lane 2 must equal 0xAB (qual 0x56)
    wr(4'd0, 32'h0000_2002); wr(4'd2, 32'h00AB_0000); wr(4'd4, 32'h56);
    cyc(1'b0, 1'b0, 2'd0, 32'h0000_2002, 32'h00AB_0000, 1'b1, 1'b1, 2'b01, "R7 lane equal");
    cyc(1'b0, 1'b0, 2'd0, 32'h0000_2002, 32'h00AC_0000, 1'b1, 1'b0, 2'b01, "R7 lane differs");
    cyc(1'b0, 1'b0, 2'd0, 32'h0000_2002, 32'h12AB_3456, 1'b1, 1'b1, 2'b01, "R7 other lanes ignored");
    wr(4'd11, 32'h1);
    wr(4'd7, 32'hFFFF_FFFF); wr(4'd8, 32'h0);
    cyc(1'b1, 1'b0, 2'd1, 32'h0003_1414, 32'h0, 1'b1, 1'b1, 2'b10, "R7 fetch skips data");
    wr(4'd11, 32'h2);

    // both channels fetch 0x100
    wr(4'd0, 32'h100); wr(4'd2, 32'h0); wr(4'd4, 32'h45); wr(4'd5, 32'h100);
    fetch(32'h100, 1'b1, 2'b11, "R2 both channels same cycle");
    wr(4'd11, 32'h3);

    // sequential mode
    wr(4'd10, 32'h8);
    fetch(32'h100, 1'b0, 2'b01, "R10 both match unarmed only arms");
    fetch(32'h100, 1'b1, 2'b11, "R9 armed then B breaks");
    wr(4'd11, 32'h3);
    wr(4'd5, 32'h200);
    fetch(32'h200, 1'b0, 2'b00, "R9 B before A ignored");
    fetch(32'h100, 1'b0, 2'b01, "R9 A arms");
    fetch(32'h300, 1'b0, 2'b01, "R9 armed held over miss");
    fetch(32'h200, 1'b1, 2'b11, "R9 B after A breaks");
    fetch(32'h200, 1'b0, 2'b11, "R9 disarmed after break");
    wr(4'd11, 32'h3);
    fetch(32'h100, 1'b0, 2'b01, "R11 arm before rewrite");
    wr(4'd10, 32'h8);
    fetch(32'h200, 1'b0, 2'b01, "R11 control write disarms");
    wr(4'd10, 32'h0);
    fetch(32'h200, 1'b1, 2'b11, "R2 independent again");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule